// File: doc/BRIEF.md
# Serial Audio Word Receiver

This block receives a three-wire serial audio stream as the slave end of the link: an external transmitter drives the bit clock, the channel-select line and the data line, and the block turns each channel word back into a parallel sample. It oversamples all three lines with the system clock, resynchronises them, and reacts to each rising bit-clock edge.

The width of the transmitted words does not have to match the receive width `W`. Each word is taken most significant bit first. A shorter word is padded with zeros at the low end. A longer word keeps only its first `W` bits. Word boundaries come only from changes of the channel-select line.

A completed left/right pair leaves the block on a valid/ready output. `smp_valid` rises when a right word completes after a left word. It then stays high, with stable data, until the cycle in which `smp_ready` is high. The receiver cannot stall the transmitter, so back-pressure never slows the link. If a new pair completes while the previous one is still waiting, the new pair replaces the old one.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset `smp_valid` is 0 and `smp_left` and `smp_right` are all zeros.
- R2: Data bits are taken on rising edges of `ser_clk`, most significant bit first. A word of exactly `W` bits is reproduced unchanged.
- R3: A word shorter than `W` bits is placed in the upper bits of the sample, and the remaining low bits are 0.
- R4: A word longer than `W` bits keeps its first `W` bits. All later bits are dropped.
- R5: `word_sel` low (0) marks the left channel and high (1) marks the right channel. At the first rising `ser_clk` edge where `word_sel` differs from its value at the previous rising edge, the bit taken at that edge is the last bit of the previous word. The next bit is the MSB of the new word.
- R6: After reset, the word in progress when the first `word_sel` change arrives is discarded as a partial word.
- R7: A pair is emitted only when a completed right word follows a completed left word. A right word without a preceding left word produces no output.
- R8: `smp_valid` stays high, with `smp_left` and `smp_right` stable, while `smp_ready` is low. It falls in the cycle after a handshake, unless a new pair loads in that same cycle.
- R9: A pair that completes while `smp_valid` is still high replaces the waiting pair.
- R10: The per-word bit counter stops at `W`, so the excess bits of a long word never alter the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock from the transmitter |
| word_sel | input | 1 | Channel select: 0 left, 1 right |
| ser_data | input | 1 | Serial data, MSB first |
| smp_valid | output | 1 | Sample pair available |
| smp_ready | input | 1 | Consumer accepts the pair |
| smp_left | output | W | Left-channel sample |
| smp_right | output | W | Right-channel sample |

## Verification
The bench builds the receiver with `W` = 12 and two synchronizer stages. With that width, single-bit, 3-, 7- and 8-bit words exercise zero padding, and 12-bit words fit exactly. Words of 20 and 32 bits exercise truncation and counter saturation. The bit clock runs at one eighth of the system clock, so every edge is seen through the synchronizers. The bench also holds `smp_ready` low across two frames to exercise holding and replacement of a waiting pair.

// File: rtl/arx_pkg.sv
package arx_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/arx_sampler.sv
module arx_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic bit_stb,
  output logic bit_val,
  output logic ws_val
);
  localparam int LINES = 3;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] stage [SYNC_STAGES];
  logic [LINES-1:0] synced;
  logic             sck_q;

  assign raw = {sck_i, ws_i, sd_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= '0;
      sck_q <= 1'b0;
    end else begin
      stage[0] <= raw;
      for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
      sck_q <= stage[SYNC_STAGES-1][2];
    end
  end

  assign synced  = stage[SYNC_STAGES-1];
  assign bit_stb = synced[2] & ~sck_q;
  assign ws_val  = synced[1];
  assign bit_val = synced[0];
endmodule

// File: rtl/arx_deser.sv
module arx_deser
  import arx_pkg::*;
#(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          bit_val,
  input  logic          ws_val,
  output logic          word_done,
  output chan_e         word_ch,
  output logic [W-1:0]  word_data,
  output logic [CW-1:0] bit_count
);
  localparam logic [CW-1:0] CNT_MAX = CW'(W);

  logic [W-1:0] acc, acc_nx;
  logic         ws_prev;
  logic         locked;

  // Place the incoming bit at its MSB-first slot while room remains.
  always_comb begin
    acc_nx = acc;
    if (bit_count < CNT_MAX) acc_nx[W-1-int'(bit_count)] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      bit_count <= '0;
      ws_prev   <= 1'b0;
      locked    <= 1'b0;
      word_done <= 1'b0;
      word_ch   <= CH_LEFT;
      word_data <= '0;
    end else begin
      word_done <= 1'b0;
      if (bit_stb) begin
        if (ws_val != ws_prev) begin
          // Channel change: this bit closes the current word.
          ws_prev   <= ws_val;
          locked    <= 1'b1;
          word_done <= locked;
          word_ch   <= chan_e'(ws_prev);
          word_data <= acc_nx;
          acc       <= '0;
          bit_count <= '0;
        end else begin
          acc <= acc_nx;
          if (bit_count < CNT_MAX) bit_count <= bit_count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arx_pair.sv
module arx_pair
  import arx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_done,
  input  chan_e        word_ch,
  input  logic [W-1:0] word_data,
  input  logic         out_ready,
  output logic         pair_load,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right
);
  logic [W-1:0] left_hold;
  logic         left_ok;

  assign pair_load = word_done && (word_ch == CH_RIGHT) && left_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0;
      left_ok   <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      if (word_done && word_ch == CH_LEFT) begin
        left_hold <= word_data;
        left_ok   <= 1'b1;
      end
      if (pair_load) begin
        out_left  <= left_hold;
        out_right <= word_data;
        out_valid <= 1'b1;
        left_ok   <= 1'b0;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import arx_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         word_sel,
  input  logic         ser_data,
  output logic         smp_valid,
  input  logic         smp_ready,
  output logic [W-1:0] smp_left,
  output logic [W-1:0] smp_right
);
  localparam int CW = $clog2(W + 1);

  logic          bit_stb, bit_val, ws_val;
  logic          word_done, pair_load;
  chan_e         word_ch;
  logic [W-1:0]  word_data;
  logic [CW-1:0] bit_count;

  arx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .sck_i(ser_clk), .ws_i(word_sel), .sd_i(ser_data),
    .bit_stb(bit_stb), .bit_val(bit_val), .ws_val(ws_val)
  );

  arx_deser #(.W(W)) u_deser (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb), .bit_val(bit_val), .ws_val(ws_val),
    .word_done(word_done), .word_ch(word_ch), .word_data(word_data),
    .bit_count(bit_count)
  );

  arx_pair #(.W(W)) u_pair (
    .clk(clk), .rst_n(rst_n),
    .word_done(word_done), .word_ch(word_ch), .word_data(word_data),
    .out_ready(smp_ready), .pair_load(pair_load),
    .out_valid(smp_valid), .out_left(smp_left), .out_right(smp_right)
  );
endmodule

// File: rtl/arx_checker.sv
module arx_checker #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_stb,
  input logic [CW-1:0] bit_count,
  input logic          word_done,
  input logic          pair_load,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic [W-1:0]  smp_left,
  input logic [W-1:0]  smp_right
);
  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= CW'(W));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready && !pair_load |=>
      smp_valid && $stable(smp_left) && $stable(smp_right));

  // R8
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready && !pair_load |=> !smp_valid);

  // R7
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_load |=> smp_valid);

  // R5
  done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(bit_stb));
endmodule

bind serial_audio_rx arx_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_count(bit_count),
  .word_done(word_done), .pair_load(pair_load), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right)
);

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;
  localparam int W = 12;
  localparam int NV = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, word_sel = 1'b0, ser_data = 1'b0;
  logic smp_ready = 1'b1;
  logic smp_valid;
  logic [W-1:0] smp_left, smp_right;

  int checks = 0, errors = 0;
  int cap_n = 0;
  logic [W-1:0] cap_l = '0, cap_r = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_audio_rx #(.W(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .word_sel(word_sel),
    .ser_data(ser_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right)
  );

  // Records every accepted pair.
  always @(negedge clk)
    if (rst_n && smp_valid && smp_ready) begin
      cap_n <= cap_n + 1;
      cap_l <= smp_left;
      cap_r <= smp_right;
    end

  // {left value, left length, right value, right length}
  localparam logic [75:0] VEC [NV] = '{
    {32'h00000ABC, 6'd12, 32'h00000123, 6'd12},
    {32'h000000A5, 6'd8,  32'h0000003C, 6'd8 },
    {32'h000FEDCB, 6'd20, 32'h00012345, 6'd20},
    {32'h00000001, 6'd1,  32'h00000000, 6'd1 },
    {32'hDEADBEEF, 6'd32, 32'h000000F0, 6'd12},
    {32'h00000005, 6'd3,  32'h0000006B, 6'd7 }
  };

  function automatic logic [W-1:0] expect_word(logic [31:0] v, int len);
    if (len >= W) return W'(v >> (len - W));
    return W'(v << (W - len));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, logic w);
    @(negedge clk);
    ser_clk = 1'b0; ser_data = b; word_sel = w;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One word; its last bit already carries the next channel's select level.
  task automatic send_word(logic ch, logic [31:0] v, int len, logic nxt);
    for (int i = 0; i < len; i++)
      send_bit(v[len-1-i], (i == len - 1) ? nxt : ch);
  endtask

  task automatic send_frame(logic [31:0] lv, int ll, logic [31:0] rv, int rl);
    send_word(1'b0, lv, ll, 1'b1);
    send_word(1'b1, rv, rl, 1'b0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid", 32'(smp_valid), 0);
    check("R1 left", 32'(smp_left), 0);
    check("R1 right", 32'(smp_right), 0);

    // Partial left word, then a right word with no completed left: no pair.
    send_word(1'b0, 32'h3, 2, 1'b1);
    send_word(1'b1, 32'h5A5, 12, 1'b0);
    repeat (8) @(negedge clk);
    check("R6 R7 no pair", 32'(cap_n), 0);
    check("R7 valid low", 32'(smp_valid), 0);

    // R2 R3 R4 R5 R10: table of word lengths around W.
    for (int k = 0; k < NV; k++) begin
      base = cap_n;
      send_frame(VEC[k][75:44], int'(VEC[k][43:38]), VEC[k][37:6], int'(VEC[k][5:0]));
      check("R2 R5 pair count", 32'(cap_n), 32'(base + 1));
      check("R2 R3 R4 R10 left", 32'(cap_l),
            32'(expect_word(VEC[k][75:44], int'(VEC[k][43:38]))));
      check("R2 R3 R4 R10 right", 32'(cap_r),
            32'(expect_word(VEC[k][37:6], int'(VEC[k][5:0]))));
    end

    // R8 R9: back-pressure and replacement.
    smp_ready = 1'b0;
    base = cap_n;
    send_frame(32'h111, 12, 32'h222, 12);
    check("R8 valid held", 32'(smp_valid), 1);
    repeat (20) @(negedge clk);
    check("R8 still valid", 32'(smp_valid), 1);
    check("R8 left stable", 32'(smp_left), 32'h111);
    send_frame(32'h33, 8, 32'h4444, 16);
    check("R9 left replaced", 32'(smp_left), 32'h330);
    check("R9 right replaced", 32'(smp_right), 32'h444);
    check("R8 nothing taken", 32'(cap_n), 32'(base));
    smp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 one handshake", 32'(cap_n), 32'(base + 1));
    check("R9 newest pair", 32'(cap_l), 32'h330);
    check("R8 valid dropped", 32'(smp_valid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule